// File: doc/BRIEF.md
# Dual Mailbox Ring Engine

This block runs the host side of a mailbox array kept in shared memory between a host and a storage adapter. The array is split in two halves of equal size: the first `NBOX` entries carry requests towards the adapter and the next `NBOX` entries carry completions back. Each half has its own index, and each index wraps around within its half.

To post a request, a client hands over a control-block pointer on a valid/ready handshake. The engine writes the pointer bytes into the next outgoing entry, then writes the start code, and then raises a one-cycle doorbell that carries the start opcode. An interrupt pulse tells the engine to look for completions. It then reads incoming entries from its saved index onward. Each entry with a nonzero code is reported on a valid/ready handshake and then freed by writing a zero code. The scan stops at the first entry whose code is zero.

Two entry layouts exist, and the `mode32` input selects one of them. It must stay constant between resets. All memory traffic goes through one byte-wide synchronous RAM port with a read latency of one cycle. The array starts at address 0 of that port.

Top module: `mbx_ring_engine`

## Requirements
- R1: After synchronous reset, `post_ready` is 1, and `cpl_valid`, `doorbell` and `mem_en` are 0. The outgoing index is 0 and the incoming index is `NBOX`.
- R2: With `mode32`=0, entry e occupies bytes 4e..4e+3. A post writes the pointer bits [23:16], [15:8] and [7:0] to offsets 1, 2 and 3 in that order, and writes code 0x01 to offset 0.
- R3: With `mode32`=1, entry e occupies bytes 8e..8e+7. A post writes pointer byte i (bits 8i+7:8i) to offset i for i = 0..3, and writes code 0x01 to offset 7. Offsets 4 to 6 of an outgoing entry are never written.
- R4: The code byte of a posted entry is written after all of its pointer bytes. On the cycle after that code write, `doorbell` is high for exactly one cycle and `door_op` reads 0x02.
- R5: Successive posts use outgoing entries 0, 1, .., NBOX-1 and then wrap to entry 0.
- R6: The completion scan starts at entry `NBOX`, steps through 2*NBOX-1 and then wraps back to entry `NBOX`. Every memory address stays inside the array.
- R7: An `irq` pulse starts a scan. The scan reports every consecutive incoming entry whose code byte is nonzero, in entry order, and stops at the first entry with a zero code. A scan that finds a zero code at once reports nothing.
- R8: A completion carries the pointer and the nonzero code byte. In 32-bit mode the pointer is read least significant byte first from offsets 0..3, adapter status comes from offset 4 and device status from offset 5. In 24-bit mode the pointer is read most significant byte first from offsets 1..3, and bits [31:24] and both status outputs are zero.
- R9: Once a completion is accepted, the code byte of that entry is written to 0x00. The entry's other bytes are left unchanged.
- R10: While `cpl_valid` is high and `cpl_ready` is low, `cpl_valid` and all completion fields hold, and the scan does not advance.
- R11: When a post is waiting and the scan has completed an entry, the post is served before the next incoming entry is read. `post_ready` and `cpl_valid` are never high together. The scan then resumes at its saved index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode32 | input | 1 | 1 selects 8-byte entries, 0 selects 4-byte entries |
| post_valid | input | 1 | Post request valid |
| post_ptr | input | 32 | Control-block pointer to post (low 24 bits in 24-bit mode) |
| post_ready | output | 1 | Engine can accept a post |
| doorbell | output | 1 | One-cycle start-mailbox doorbell pulse |
| door_op | output | 8 | Doorbell opcode, 0x02 while `doorbell` is high |
| irq | input | 1 | Completion interrupt pulse, starts a scan |
| cpl_valid | output | 1 | Completion record valid |
| cpl_ready | input | 1 | Consumer accepts the completion |
| cpl_ptr | output | 32 | Completed control-block pointer |
| cpl_code | output | 8 | Completion code (1 ok, 2 aborted, 3 abort target not found, 4 error) |
| cpl_astat | output | 8 | Adapter status byte (32-bit mode) |
| cpl_dstat | output | 8 | Device status byte (32-bit mode) |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | IW+3 | Byte address in the array |
| mem_wdata | output | 8 | Write data byte |
| mem_rdata | input | 8 | Read data, valid the cycle after a read |

## Verification
The bench runs both entry layouts on a four-entry ring. It posts six pointers whose byte values all differ, so a swapped byte order, a wrong offset or a missed wrap of the outgoing index shows up in the memory image. In 32-bit mode it pre-fills the status and pad bytes of the outgoing entries to catch any stray write. It loads batches of completions with every code value and different status bytes, and it places them so that the incoming index wraps. The consumer stalls for zero, one or two cycles, which separates the hold behaviour from plain data errors. A post raised while a completion is held tests the priority rule, and an interrupt with no pending entries tests the empty scan.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam logic [7:0] MB_FREE     = 8'h00;
    localparam logic [7:0] MB_START    = 8'h01;
    localparam logic [7:0] MB_ABORT    = 8'h02;
    localparam logic [7:0] MB_OK       = 8'h01;
    localparam logic [7:0] MB_ABORTED  = 8'h02;
    localparam logic [7:0] MB_NOTFOUND = 8'h03;
    localparam logic [7:0] MB_ERROR    = 8'h04;
    localparam logic [7:0] DOOR_START  = 8'h02;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PWR, ST_PCODE, ST_BELL,
        ST_RCODE, ST_CCODE, ST_RD, ST_CAP, ST_OFFER, ST_CLR
    } mbx_state_e;

    typedef struct packed {
        logic [31:0] ptr;
        logic [7:0]  code;
        logic [7:0]  astat;
        logic [7:0]  dstat;
    } mbx_cpl_t;

    // offset of the code byte inside an entry
    function automatic logic [2:0] code_off(input logic m32);
        return m32 ? 3'd7 : 3'd0;
    endfunction

    // pointer bytes written by a post
    function automatic logic [2:0] ptr_len(input logic m32);
        return m32 ? 3'd4 : 3'd3;
    endfunction

    // body bytes read for a completion (pointer plus status in wide mode)
    function automatic logic [2:0] rd_len(input logic m32);
        return m32 ? 3'd6 : 3'd3;
    endfunction

    // offset of body byte k
    function automatic logic [2:0] body_off(input logic m32, input logic [2:0] k);
        return m32 ? k : k + 3'd1;
    endfunction

    // pointer byte k in the write order of the selected layout
    function automatic logic [7:0] post_byte(input logic m32, input logic [31:0] p,
                                             input logic [2:0] k);
        logic [4:0] sh;
        sh = m32 ? {k[1:0], 3'b000} : 5'd16 - {k[1:0], 3'b000};
        return p[sh +: 8];
    endfunction

endpackage

// File: rtl/mbx_wrap_idx.sv
module mbx_wrap_idx #(
    parameter int IW    = 7,
    parameter int BASE  = 0,
    parameter int COUNT = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [IW-1:0] idx
);
    localparam logic [IW-1:0] FIRST = IW'(BASE);
    localparam logic [IW-1:0] LAST  = IW'(BASE + COUNT - 1);

    always_ff @(posedge clk) begin
        if (rst)
            idx <= FIRST;
        else if (step)
            idx <= (idx == LAST) ? FIRST : idx + 1'b1;
    end
endmodule

// File: rtl/mbx_addr.sv
module mbx_addr #(
    parameter int IW = 7,
    parameter int AW = IW + 3
) (
    input  logic          m32,
    input  logic [IW-1:0] idx,
    input  logic [2:0]    off,
    output logic [AW-1:0] addr
);
    always_comb begin
        if (m32)
            addr = {idx, 3'b000} | AW'(off);
        else
            addr = AW'({idx, 2'b00}) | AW'(off);
    end
endmodule

// File: rtl/mbx_ring_engine.sv
module mbx_ring_engine
    import mbx_pkg::*;
#(
    parameter  int NBOX = 64,
    localparam int IW   = $clog2(2 * NBOX),
    localparam int AW   = IW + 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode32,
    input  logic          post_valid,
    input  logic [31:0]   post_ptr,
    output logic          post_ready,
    output logic          doorbell,
    output logic [7:0]    door_op,
    input  logic          irq,
    output logic          cpl_valid,
    input  logic          cpl_ready,
    output logic [31:0]   cpl_ptr,
    output logic [7:0]    cpl_code,
    output logic [7:0]    cpl_astat,
    output logic [7:0]    cpl_dstat,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata
);
    mbx_state_e    state;
    logic [2:0]    cnt;
    logic [31:0]   ptr_r;
    mbx_cpl_t      cpl_r;
    logic          scan_pend;
    logic          out_step, in_step;
    logic [IW-1:0] out_idx, in_idx, cur_idx;
    logic [2:0]    cur_off;

    mbx_wrap_idx #(.IW(IW), .BASE(0), .COUNT(NBOX)) u_out_idx (
        .clk(clk), .rst(rst), .step(out_step), .idx(out_idx));

    mbx_wrap_idx #(.IW(IW), .BASE(NBOX), .COUNT(NBOX)) u_in_idx (
        .clk(clk), .rst(rst), .step(in_step), .idx(in_idx));

    mbx_addr #(.IW(IW), .AW(AW)) u_addr (
        .m32(mode32), .idx(cur_idx), .off(cur_off), .addr(mem_addr));

    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = MB_FREE;
        cur_idx   = in_idx;
        cur_off   = code_off(mode32);
        out_step  = 1'b0;
        in_step   = 1'b0;
        doorbell  = 1'b0;
        cpl_valid = 1'b0;
        unique case (state)
            ST_PWR: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                cur_idx   = out_idx;
                cur_off   = body_off(mode32, cnt);
                mem_wdata = post_byte(mode32, ptr_r, cnt);
            end
            ST_PCODE: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                cur_idx   = out_idx;
                mem_wdata = MB_START;
            end
            ST_BELL: begin
                doorbell = 1'b1;
                out_step = 1'b1;
            end
            ST_RCODE: mem_en = 1'b1;
            ST_RD: begin
                mem_en  = 1'b1;
                cur_off = body_off(mode32, cnt);
            end
            ST_OFFER: cpl_valid = 1'b1;
            ST_CLR: begin
                mem_en  = 1'b1;
                mem_we  = 1'b1;
                in_step = 1'b1;
            end
            default: ;
        endcase
    end

    assign post_ready = (state == ST_IDLE);
    assign door_op    = doorbell ? DOOR_START : 8'h00;
    assign cpl_ptr    = cpl_r.ptr;
    assign cpl_code   = cpl_r.code;
    assign cpl_astat  = cpl_r.astat;
    assign cpl_dstat  = cpl_r.dstat;

    // scan request is sticky until an empty entry ends the scan
    always_ff @(posedge clk) begin
        if (rst)
            scan_pend <= 1'b0;
        else if (irq)
            scan_pend <= 1'b1;
        else if (state == ST_CCODE && mem_rdata == MB_FREE)
            scan_pend <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            ptr_r <= '0;
            cpl_r <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (post_valid) begin
                        ptr_r <= post_ptr;
                        cnt   <= '0;
                        state <= ST_PWR;
                    end else if (scan_pend) begin
                        state <= ST_RCODE;
                    end
                end
                ST_PWR: begin
                    if (cnt == ptr_len(mode32) - 3'd1)
                        state <= ST_PCODE;
                    else
                        cnt <= cnt + 3'd1;
                end
                ST_PCODE: state <= ST_BELL;
                ST_BELL:  state <= ST_IDLE;
                ST_RCODE: state <= ST_CCODE;
                ST_CCODE: begin
                    if (mem_rdata == MB_FREE) begin
                        state <= ST_IDLE;
                    end else begin
                        cpl_r       <= '0;
                        cpl_r.code  <= mem_rdata;
                        cnt         <= '0;
                        state       <= ST_RD;
                    end
                end
                ST_RD: state <= ST_CAP;
                ST_CAP: begin
                    if (!mode32)
                        cpl_r.ptr <= {cpl_r.ptr[23:0], mem_rdata};
                    else begin
                        case (cnt)
                            3'd4:    cpl_r.astat <= mem_rdata;
                            3'd5:    cpl_r.dstat <= mem_rdata;
                            default: cpl_r.ptr[{cnt[1:0], 3'b000} +: 8] <= mem_rdata;
                        endcase
                    end
                    if (cnt == rd_len(mode32) - 3'd1)
                        state <= ST_OFFER;
                    else begin
                        cnt   <= cnt + 3'd1;
                        state <= ST_RD;
                    end
                end
                ST_OFFER: if (cpl_ready) state <= ST_CLR;
                ST_CLR:   state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mbx_ring_chk.sv
module mbx_ring_chk #(
    parameter int NBOX = 64,
    parameter int AW   = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          mode32,
    input logic          post_ready,
    input logic          doorbell,
    input logic          cpl_valid,
    input logic          cpl_ready,
    input logic [31:0]   cpl_ptr,
    input logic [7:0]    cpl_code,
    input logic [7:0]    cpl_astat,
    input logic [7:0]    cpl_dstat,
    input logic          mem_en,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [7:0]    mem_wdata
);
    assert_cpl_hold_R10: assert property (@(posedge clk) disable iff (rst)
        cpl_valid && !cpl_ready |=> cpl_valid && $stable(cpl_ptr) && $stable(cpl_code)
                                    && $stable(cpl_astat) && $stable(cpl_dstat));

    assert_bell_single_R4: assert property (@(posedge clk) disable iff (rst)
        doorbell |=> !doorbell);

    assert_bell_after_code_R4: assert property (@(posedge clk) disable iff (rst)
        doorbell |-> $past(mem_en && mem_we && mem_wdata == 8'h01));

    assert_code_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
        cpl_valid |-> cpl_code != 8'h00);

    assert_narrow_fields_R8: assert property (@(posedge clk) disable iff (rst)
        cpl_valid && !mode32 |-> cpl_astat == 8'h00 && cpl_dstat == 8'h00
                                 && cpl_ptr[31:24] == 8'h00);

    assert_addr_span_R6: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> int'(mem_addr) < (mode32 ? 16 * NBOX : 8 * NBOX));

    assert_post_excl_R11: assert property (@(posedge clk) disable iff (rst)
        post_ready |-> !cpl_valid);
endmodule

bind mbx_ring_engine mbx_ring_chk #(.NBOX(NBOX), .AW(AW)) u_chk (
    .clk(clk), .rst(rst), .mode32(mode32), .post_ready(post_ready),
    .doorbell(doorbell), .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
    .cpl_ptr(cpl_ptr), .cpl_code(cpl_code), .cpl_astat(cpl_astat),
    .cpl_dstat(cpl_dstat), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata));

// File: tb/mbx_ring_engine_tb.sv
module mbx_ring_engine_tb;
    localparam int N   = 4;
    localparam int IW  = $clog2(2 * N);
    localparam int AW  = IW + 3;
    localparam int MSZ = 1 << AW;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, mode32, post_valid, irq, cpl_ready;
    logic [31:0] post_ptr;
    logic post_ready, doorbell, cpl_valid, mem_en, mem_we;
    logic [7:0] door_op, cpl_code, cpl_astat, cpl_dstat, mem_wdata, mem_rdata;
    logic [31:0] cpl_ptr;
    logic [AW-1:0] mem_addr;

    logic [7:0]    ram [0:MSZ-1];
    logic          adp_we, adp_clr;
    logic [AW-1:0] adp_addr;
    logic [7:0]    adp_wd;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    mbx_ring_engine #(.NBOX(N)) u_dut (
        .clk(clk), .rst(rst), .mode32(mode32), .post_valid(post_valid),
        .post_ptr(post_ptr), .post_ready(post_ready), .doorbell(doorbell),
        .door_op(door_op), .irq(irq), .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
        .cpl_ptr(cpl_ptr), .cpl_code(cpl_code), .cpl_astat(cpl_astat),
        .cpl_dstat(cpl_dstat), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

    // shared memory model: engine port plus an adapter-side write port
    always @(posedge clk) begin
        if (adp_clr) begin
            for (int i = 0; i < MSZ; i++) ram[i] <= 8'h00;
        end else if (mem_en && mem_we) ram[mem_addr] <= mem_wdata;
        else if (adp_we) ram[adp_addr] <= adp_wd;
        if (mem_en) mem_rdata <= ram[mem_addr];
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int esz(); return mode32 ? 8 : 4; endfunction
    function automatic int coff(); return mode32 ? 7 : 0; endfunction

    task automatic aw(input int a, input logic [7:0] v);
        adp_we = 1'b1; adp_addr = AW'(a); adp_wd = v;
        @(negedge clk);
        adp_we = 1'b0;
    endtask

    task automatic do_reset(input logic m);
        rst = 1'b1; mode32 = m; post_valid = 0; post_ptr = 0; irq = 0;
        cpl_ready = 0; adp_we = 0; adp_addr = 0; adp_wd = 0; adp_clr = 1;
        repeat (3) @(negedge clk);
        adp_clr = 0; rst = 1'b0;
        @(negedge clk);
        chk(post_ready == 1 && cpl_valid == 0 && doorbell == 0 && mem_en == 0,
            "R1 reset outputs", {post_ready, cpl_valid, doorbell, mem_en}, 32'h8);
    endtask

    // read back a posted pointer from the model in the layout of R2/R3
    function automatic logic [31:0] out_ptr(input int slot);
        int b = slot * esz();
        if (mode32) return {ram[b+3], ram[b+2], ram[b+1], ram[b]};
        return {8'h00, ram[b+1], ram[b+2], ram[b+3]};
    endfunction

    task automatic post_one(input logic [31:0] p, input int slot);
        int nw = 0;
        int la = -1;
        logic [7:0] ld = 0;
        bit rang = 0;
        post_valid = 1; post_ptr = p;
        for (int i = 0; i < 20 && !post_ready; i++) @(negedge clk);
        @(negedge clk);
        post_valid = 0;
        for (int i = 0; i < 20; i++) begin
            if (doorbell) begin rang = 1; break; end
            if (mem_en && mem_we) begin nw++; la = int'(mem_addr); ld = mem_wdata; end
            @(negedge clk);
        end
        chk(rang, "R4 doorbell raised", 32'(rang), 1);
        chk(door_op == 8'h02, "R4 doorbell opcode", 32'(door_op), 32'h02);
        chk(nw == (mode32 ? 5 : 4), "R4 write count before doorbell", nw, mode32 ? 5 : 4);
        chk(la == slot * esz() + coff() && ld == 8'h01, "R4 code written last",
            32'(la), 32'(slot * esz() + coff()));
        chk(out_ptr(slot) == (mode32 ? p : {8'h00, p[23:0]}),
            mode32 ? "R3 pointer layout" : "R2 pointer layout", out_ptr(slot), p);
        chk(ram[slot*esz()+coff()] == 8'h01, "R5 entry slot code", 32'(ram[slot*esz()+coff()]), 1);
        if (mode32)
            chk({ram[slot*8+4], ram[slot*8+5], ram[slot*8+6]} == 24'hEEEEEE,
                "R3 status bytes untouched", {ram[slot*8+4], ram[slot*8+5], ram[slot*8+6]}, 32'hEEEEEE);
        @(negedge clk);
        chk(doorbell == 0, "R4 doorbell single cycle", 32'(doorbell), 0);
    endtask

    task automatic fill_in(input int s, input logic [31:0] p, input logic [7:0] c,
                           input logic [7:0] a, input logic [7:0] d);
        int b = (N + s) * esz();
        if (mode32) begin
            aw(b, p[7:0]); aw(b+1, p[15:8]); aw(b+2, p[23:16]); aw(b+3, p[31:24]);
            aw(b+4, a); aw(b+5, d); aw(b+6, 8'h5A); aw(b+7, c);
        end else begin
            aw(b+1, p[23:16]); aw(b+2, p[15:8]); aw(b+3, p[7:0]); aw(b, c);
        end
    endtask

    task automatic pulse_irq();
        irq = 1; @(negedge clk); irq = 0;
    endtask

    task automatic collect_one(input logic [31:0] p, input logic [7:0] c,
                               input logic [7:0] a, input logic [7:0] d, input int stall);
        logic [31:0] ep = mode32 ? p : {8'h00, p[23:0]};
        logic [7:0]  ea = mode32 ? a : 8'h00;
        logic [7:0]  ed = mode32 ? d : 8'h00;
        for (int i = 0; i < 60 && !cpl_valid; i++) @(negedge clk);
        chk(cpl_valid, "R7 completion reported", 32'(cpl_valid), 1);
        cpl_ready = 0;
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            chk(cpl_valid && cpl_ptr == ep, "R10 held during stall", cpl_ptr, ep);
        end
        chk(cpl_ptr == ep, "R8 completion pointer", cpl_ptr, ep);
        chk(cpl_code == c, "R8 completion code", 32'(cpl_code), 32'(c));
        chk({cpl_astat, cpl_dstat} == {ea, ed}, "R8 status bytes",
            {cpl_astat, cpl_dstat}, {ea, ed});
        cpl_ready = 1;
        @(negedge clk);
        cpl_ready = 0;
    endtask

    task automatic expect_quiet(input string req);
        bit seen = 0;
        for (int i = 0; i < 30; i++) begin
            if (cpl_valid) seen = 1;
            @(negedge clk);
        end
        chk(!seen, req, 32'(seen), 0);
    endtask

    task automatic check_freed(input int s, input logic [31:0] p);
        int b = (N + s) * esz();
        logic [31:0] got = mode32 ? {ram[b+3], ram[b+2], ram[b+1], ram[b]}
                                  : {8'h00, ram[b+1], ram[b+2], ram[b+3]};
        chk(ram[b+coff()] == 8'h00, "R9 code cleared", 32'(ram[b+coff()]), 0);
        chk(got == (mode32 ? p : {8'h00, p[23:0]}), "R9 body unchanged", got, p);
    endtask

    task automatic run_mode(input logic m);
        logic [31:0] pp [0:5];
        bit door_seen;
        do_reset(m);
        if (m) for (int e = 0; e < N; e++) begin
            aw(e*8+4, 8'hEE); aw(e*8+5, 8'hEE); aw(e*8+6, 8'hEE);
        end
        // R5: six posts wrap the outgoing index past N-1
        for (int k = 0; k < 6; k++) begin
            pp[k] = 32'h1020_3040 + 32'(k) * 32'h1103_0507;
            post_one(pp[k], k % N);
        end
        chk(out_ptr(0) == (m ? pp[4] : {8'h00, pp[4][23:0]}), "R5 wrap to entry 0",
            out_ptr(0), pp[4]);
        // R7/R8/R9/R10: first batch with every code value
        fill_in(0, 32'hA1B2C3D4, 8'h01, 8'h11, 8'h21);
        fill_in(1, 32'h0F1E2D3C, 8'h02, 8'h12, 8'h22);
        fill_in(2, 32'h55667788, 8'h04, 8'h13, 8'h23);
        pulse_irq();
        collect_one(32'hA1B2C3D4, 8'h01, 8'h11, 8'h21, 0);
        collect_one(32'h0F1E2D3C, 8'h02, 8'h12, 8'h22, 2);
        collect_one(32'h55667788, 8'h04, 8'h13, 8'h23, 1);
        expect_quiet("R7 scan stops at free entry");
        check_freed(0, 32'hA1B2C3D4);
        check_freed(2, 32'h55667788);
        // R6: second batch wraps the incoming index back to N
        fill_in(3, 32'hCAFE0123, 8'h03, 8'h31, 8'h41);
        fill_in(0, 32'h89ABCDEF, 8'h01, 8'h32, 8'h42);
        fill_in(1, 32'h13579BDF, 8'h04, 8'h33, 8'h43);
        pulse_irq();
        collect_one(32'hCAFE0123, 8'h03, 8'h31, 8'h41, 1);
        collect_one(32'h89ABCDEF, 8'h01, 8'h32, 8'h42, 0);
        collect_one(32'h13579BDF, 8'h04, 8'h33, 8'h43, 0);
        expect_quiet("R6 wrapped scan stops");
        check_freed(3, 32'hCAFE0123);
        check_freed(1, 32'h13579BDF);
        // R11: post raised while a completion is held
        fill_in(2, 32'h2468ACE0, 8'h01, 8'h51, 8'h61);
        fill_in(3, 32'h7531FDB9, 8'h02, 8'h52, 8'h62);
        pulse_irq();
        for (int i = 0; i < 60 && !cpl_valid; i++) @(negedge clk);
        post_valid = 1; post_ptr = 32'hDEADBE07;
        @(negedge clk);
        @(negedge clk);
        chk(post_ready == 0 && cpl_valid == 1, "R11 post waits for held completion",
            {post_ready, cpl_valid}, 32'h1);
        cpl_ready = 1;
        @(negedge clk);
        cpl_ready = 0;
        door_seen = 0;
        for (int i = 0; i < 60; i++) begin
            if (cpl_valid) break;
            if (doorbell) door_seen = 1;
            if (post_valid && post_ready) begin
                @(negedge clk);
                post_valid = 0;
            end else @(negedge clk);
        end
        chk(door_seen, "R11 post served before next entry", 32'(door_seen), 1);
        chk(ram[2*esz()+coff()] == 8'h01, "R11 post landed in entry 2",
            32'(ram[2*esz()+coff()]), 1);
        collect_one(32'h7531FDB9, 8'h02, 8'h52, 8'h62, 0);
        expect_quiet("R11 scan resumed and stopped");
        // R7: interrupt with nothing pending
        pulse_irq();
        expect_quiet("R7 empty scan reports nothing");
    endtask

    initial begin
        run_mode(1'b0);
        run_mode(1'b1);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule